// File: doc/BRIEF.md
# Control Register Access Checker

This block executes control-register access instructions for one hart and decides whether each access is allowed. Each request carries a 12-bit register number, an operation code, a source operand (either a full-width register value or a 5-bit immediate), and the privilege mode the hart is running in. One clock after the request, the block reports three things: the value the register held before the access, whether a write took place and with what value, and whether the access was illegal.

The block owns a small register file of sample registers:

- five scratch registers, one for each privilege level plus an extra machine-level one;
- a free-running machine counter;
- a read-only user-level view of that counter;
- a read-only identity register.

Each access is one atomic step. The old value is read, the new value is formed and stored in the same clock edge, so no other access can fall in between.

The privilege an address needs is taken from address bits [9:8]. Bits [11:10] equal to 2'b11 mark a register as read-only.

Top module: `csr_gate`

## Requirements
- R1: A response is valid exactly one cycle after each request (`rsp_valid` follows `req_valid` by one clock). For a legal access, `rsp_rdata` holds the value the register had before that access.
- R2: Operation code 2'b01 (swap) always writes the source operand, with `rsp_wen`=1 and `rsp_wdata` equal to the source.
- R3: Operation code 2'b10 (set) writes old OR source. Operation code 2'b11 (clear) writes old AND NOT source.
- R4: When `req_use_imm`=1, the source is `req_imm` zero-extended to the full width, and `req_rs_data` is ignored.
- R5: A set or clear whose source is zero performs no write (`rsp_wen`=0). It is legal even on a read-only register and leaves the register unchanged.
- R6: Privilege levels are encoded 0 user, 1 supervisor, 2 hypervisor, 3 machine, both in `cur_mode` and in the required level `req_addr[9:8]`. A request from a lower mode is illegal and changes no state.
- R7: An address with `req_addr[11:10]`=2'b11 is read-only. Any access that would write it is illegal.
- R8: An address that is not implemented is illegal, and so is operation code 2'b00.
- R9: An illegal response has `rsp_illegal`=1, `rsp_wen`=0, `rsp_rdata`=0 and `rsp_wdata`=0. A legal response without a write has `rsp_wdata`=0.
- R10: The implemented registers are:
  - scratch registers 0x040, 0x140, 0x240, 0x340 and 0x7A0, which reset to 0;
  - the counter at 0xB00;
  - the read-only counter view at 0xC00;
  - the read-only identity register 0xF11, which returns `ID_VALUE`.
- R11: The counter resets to 0 and increments every cycle. A legal write to 0xB00 loads the written value instead of incrementing on that cycle. Both 0xB00 and 0xC00 read the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register number |
| req_op | input | 2 | 00 reserved, 01 swap, 10 set, 11 clear |
| req_use_imm | input | 1 | Select the immediate as source |
| req_imm | input | 5 | Immediate source operand |
| req_rs_data | input | XLEN | Register source operand |
| cur_mode | input | 2 | Current privilege mode |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | XLEN | Old register value |
| rsp_wdata | output | XLEN | Value written |
| rsp_wen | output | 1 | A write took place |
| rsp_illegal | output | 1 | Access not allowed |

## Verification
The assertions assume that the request inputs are stable around the rising edge and that a single request is handled per cycle. The stimulus meets both by driving only on the falling edge. The properties on privilege, read-only writes and zero-source set or clear read their conditions directly off the request ports. They therefore rely on `cur_mode` and `req_addr` being meaningful whenever `req_valid` is high. The bench keeps both fully defined at all times, including while the request is idle.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_HYPER = 2'd2,
        LVL_MACH  = 2'd3
    } priv_e;

    localparam int ADDR_W      = 12;
    localparam int IMM_W       = 5;
    localparam int NUM_SCRATCH = 5;

    localparam logic [ADDR_W-1:0] ADDR_CNT_RW = 12'hB00;
    localparam logic [ADDR_W-1:0] ADDR_CNT_RO = 12'hC00;
    localparam logic [ADDR_W-1:0] ADDR_IDENT  = 12'hF11;

    function automatic logic [ADDR_W-1:0] scratch_addr(input int idx);
        case (idx)
            0:       return 12'h040;
            1:       return 12'h140;
            2:       return 12'h240;
            3:       return 12'h340;
            default: return 12'h7A0;
        endcase
    endfunction

endpackage

// File: rtl/csr_gate_decode.sv
module csr_gate_decode
    import csr_gate_pkg::*;
(
    input  logic [ADDR_W-1:0]      addr,
    output logic [NUM_SCRATCH-1:0] scr_sel,
    output logic                   cnt_rw_sel,
    output logic                   cnt_ro_sel,
    output logic                   ident_sel,
    output logic                   hit,
    output logic                   read_only,
    output logic [1:0]             need_lvl
);

    for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr_match
        assign scr_sel[g] = (addr == scratch_addr(g));
    end

    always_comb begin
        cnt_rw_sel = (addr == ADDR_CNT_RW);
        cnt_ro_sel = (addr == ADDR_CNT_RO);
        ident_sel  = (addr == ADDR_IDENT);
        hit        = (|scr_sel) | cnt_rw_sel | cnt_ro_sel | ident_sel;
        read_only  = (addr[11:10] == 2'b11);
        need_lvl   = addr[9:8];
    end

endmodule

// File: rtl/csr_gate_alu.sv
module csr_gate_alu
    import csr_gate_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e          op,
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  rs_data,
    input  logic [XLEN-1:0]  old_val,
    output logic [XLEN-1:0]  new_val,
    output logic             write_req
);

    logic [XLEN-1:0] src;

    always_comb begin
        src = use_imm ? {{(XLEN-IMM_W){1'b0}}, imm} : rs_data;
        new_val   = old_val;
        write_req = 1'b0;
        unique case (op)
            OP_SWAP: begin
                new_val   = src;
                write_req = 1'b1;
            end
            OP_SET: begin
                new_val   = old_val | src;
                write_req = (src != '0);
            end
            OP_CLR: begin
                new_val   = old_val & ~src;
                write_req = (src != '0);
            end
            OP_NONE: begin
                new_val   = old_val;
                write_req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/csr_gate_regs.sv
module csr_gate_regs
    import csr_gate_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] ID_VALUE = 32'h5EC0_0A11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SCRATCH-1:0] scr_sel,
    input  logic                   cnt_rw_sel,
    input  logic                   cnt_ro_sel,
    input  logic                   ident_sel,
    input  logic                   commit,
    input  logic [XLEN-1:0]        wval,
    output logic [XLEN-1:0]        rval
);

    logic [XLEN-1:0] scr_q [NUM_SCRATCH];
    logic [XLEN-1:0] cnt_q;

    for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                scr_q[g] <= '0;
            else if (commit && scr_sel[g])
                scr_q[g] <= wval;
        end

        // R10: a scratch register keeps its value unless committed
        p_scratch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(commit && scr_sel[g]) |=> scr_q[g] == $past(scr_q[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (commit && cnt_rw_sel)
            cnt_q <= wval;
        else
            cnt_q <= cnt_q + XLEN'(1);
    end

    // R11: the counter steps by one on every cycle without a write
    p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && cnt_rw_sel) |=> cnt_q == $past(cnt_q) + XLEN'(1));

    always_comb begin
        rval = '0;
        for (int i = 0; i < NUM_SCRATCH; i++)
            if (scr_sel[i]) rval = rval | scr_q[i];
        if (cnt_rw_sel || cnt_ro_sel) rval = rval | cnt_q;
        if (ident_sel)                rval = rval | ID_VALUE;
    end

endmodule

// File: rtl/csr_gate.sv
module csr_gate
    import csr_gate_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] ID_VALUE = 32'h5EC0_0A11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [11:0]      req_addr,
    input  logic [1:0]       req_op,
    input  logic             req_use_imm,
    input  logic [4:0]       req_imm,
    input  logic [XLEN-1:0]  req_rs_data,
    input  logic [1:0]       cur_mode,
    output logic             rsp_valid,
    output logic [XLEN-1:0]  rsp_rdata,
    output logic [XLEN-1:0]  rsp_wdata,
    output logic             rsp_wen,
    output logic             rsp_illegal
);

    csr_op_e               op;
    logic [NUM_SCRATCH-1:0] scr_sel;
    logic                  cnt_rw_sel, cnt_ro_sel, ident_sel;
    logic                  hit, read_only;
    logic [1:0]            need_lvl;
    logic [XLEN-1:0]       old_val, new_val;
    logic                  write_req, legal, commit;

    assign op = csr_op_e'(req_op);

    csr_gate_decode u_decode (
        .addr       (req_addr),
        .scr_sel    (scr_sel),
        .cnt_rw_sel (cnt_rw_sel),
        .cnt_ro_sel (cnt_ro_sel),
        .ident_sel  (ident_sel),
        .hit        (hit),
        .read_only  (read_only),
        .need_lvl   (need_lvl)
    );

    csr_gate_alu #(.XLEN(XLEN)) u_alu (
        .op        (op),
        .use_imm   (req_use_imm),
        .imm       (req_imm),
        .rs_data   (req_rs_data),
        .old_val   (old_val),
        .new_val   (new_val),
        .write_req (write_req)
    );

    csr_gate_regs #(.XLEN(XLEN), .ID_VALUE(ID_VALUE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .scr_sel    (scr_sel),
        .cnt_rw_sel (cnt_rw_sel),
        .cnt_ro_sel (cnt_ro_sel),
        .ident_sel  (ident_sel),
        .commit     (commit),
        .wval       (new_val),
        .rval       (old_val)
    );

    always_comb begin
        legal  = hit && (op != OP_NONE) && (cur_mode >= need_lvl)
                 && !(read_only && write_req);
        commit = req_valid && legal && write_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_illegal <= 1'b0;
            rsp_wen     <= 1'b0;
            rsp_rdata   <= '0;
            rsp_wdata   <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_illegal <= req_valid && !legal;
            rsp_wen     <= commit;
            rsp_rdata   <= (req_valid && legal) ? old_val : '0;
            rsp_wdata   <= commit ? new_val : '0;
        end
    end

    // R1: one response per request, one cycle later
    p_resp_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_resp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: a register-source swap that writes carries the source
    p_swap_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && !req_use_imm)
        |=> (!rsp_wen || rsp_wdata == $past(req_rs_data)));

    // R5: a zero register source never writes
    p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[1] && !req_use_imm && req_rs_data == '0) |=> !rsp_wen);

    // R6: a lower mode is refused
    p_low_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_mode < req_addr[9:8]) |=> (rsp_illegal && !rsp_wen));

    // R7: a swap to a read-only number is refused
    p_ro_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[11:10] == 2'b11 && req_op == 2'b01) |=> rsp_illegal);

    // R9: an illegal response carries no data and no write
    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |-> (!rsp_wen && rsp_rdata == '0 && rsp_wdata == '0));

endmodule

// File: tb/csr_gate_tb_top.sv
module csr_gate_tb_top;

    localparam int          XLEN  = 32;
    localparam logic [31:0] IDV   = 32'h5EC0_0A11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [11:0]      req_addr = '0;
    logic [1:0]       req_op = '0;
    logic             req_use_imm = 1'b0;
    logic [4:0]       req_imm = '0;
    logic [XLEN-1:0]  req_rs_data = '0;
    logic [1:0]       cur_mode = '0;
    logic             rsp_valid;
    logic [XLEN-1:0]  rsp_rdata, rsp_wdata;
    logic             rsp_wen, rsp_illegal;

    always #10 clk = ~clk;  // 50 MHz

    csr_gate #(.XLEN(XLEN), .ID_VALUE(IDV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_op(req_op), .req_use_imm(req_use_imm), .req_imm(req_imm),
        .req_rs_data(req_rs_data), .cur_mode(cur_mode), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_wdata(rsp_wdata), .rsp_wen(rsp_wen),
        .rsp_illegal(rsp_illegal)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] m_scr [int];
    logic [31:0] m_cnt;
    logic        e_valid, e_wen, e_ill;
    logic [31:0] e_rdata, e_wdata;
    string       e_tag;

    function automatic bit is_scratch(input logic [11:0] a);
        return a == 12'h040 || a == 12'h140 || a == 12'h240 ||
               a == 12'h340 || a == 12'h7A0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_scr.delete();
            m_scr[12'h040] = '0; m_scr[12'h140] = '0; m_scr[12'h240] = '0;
            m_scr[12'h340] = '0; m_scr[12'h7A0] = '0;
            m_cnt = '0;
            e_valid = 0; e_wen = 0; e_ill = 0; e_rdata = '0; e_wdata = '0;
            e_tag = "R10";
        end else begin
            logic [31:0] src, oldv, newv;
            bit hit, ro, wr, ok, cnt_written;
            int need;
            cnt_written = 0;
            src  = req_use_imm ? {27'd0, req_imm} : req_rs_data;
            hit  = is_scratch(req_addr) || req_addr == 12'hB00 ||
                   req_addr == 12'hC00 || req_addr == 12'hF11;
            ro   = (req_addr[11:10] == 2'b11);
            need = int'(req_addr[9:8]);
            oldv = '0;
            if (is_scratch(req_addr)) oldv = m_scr[req_addr];
            else if (req_addr == 12'hB00 || req_addr == 12'hC00) oldv = m_cnt;
            else if (req_addr == 12'hF11) oldv = IDV;
            wr = (req_op == 2'b01) || (req_op[1] && src != 0);
            case (req_op)
                2'b01:   newv = src;
                2'b10:   newv = oldv | src;
                2'b11:   newv = oldv & ~src;
                default: newv = oldv;
            endcase
            ok = hit && req_op != 2'b00 && int'(cur_mode) >= need && !(ro && wr);
            if (!hit || req_op == 2'b00)        e_tag = "R8";
            else if (int'(cur_mode) < need)     e_tag = "R6";
            else if (ro && wr)                  e_tag = "R7";
            else if (req_op[1] && src == 0)     e_tag = "R5";
            else if (req_addr == 12'hB00 || req_addr == 12'hC00) e_tag = "R11";
            else if (req_use_imm)               e_tag = "R4";
            else if (req_op == 2'b01)           e_tag = "R2";
            else                                e_tag = "R3";
            if (!req_valid) e_tag = "R1";
            e_valid = req_valid;
            e_ill   = req_valid && !ok;
            e_wen   = req_valid && ok && wr;
            e_rdata = (req_valid && ok) ? oldv : '0;
            e_wdata = e_wen ? newv : '0;
            if (e_wen) begin
                if (is_scratch(req_addr)) m_scr[req_addr] = newv;
                if (req_addr == 12'hB00) begin m_cnt = newv; cnt_written = 1; end
            end
            if (!cnt_written) m_cnt = m_cnt + 1;
        end
    end

    // compare on every falling edge (R9 covers the illegal data fields)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rsp_valid !== e_valid || rsp_wen !== e_wen || rsp_illegal !== e_ill ||
                rsp_rdata !== e_rdata || rsp_wdata !== e_wdata) begin
                failures++;
                $display("FAIL %s: got v=%0b ill=%0b wen=%0b rd=%h wd=%h exp v=%0b ill=%0b wen=%0b rd=%h wd=%h",
                         e_tag, rsp_valid, rsp_illegal, rsp_wen, rsp_rdata, rsp_wdata,
                         e_valid, e_ill, e_wen, e_rdata, e_wdata);
            end
        end
    end

    task automatic req(input logic [11:0] a, input logic [1:0] op, input logic [1:0] md,
                       input logic [31:0] rs, input bit imm_sel, input logic [4:0] im);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_op = op; cur_mode = md;
        req_rs_data = rs; req_use_imm = imm_sel; req_imm = im;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: got running exp finished");
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state: outputs quiet (R1)
        checks++;
        if (rsp_valid !== 1'b0 || rsp_wen !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: got v=%0b wen=%0b exp 0 0", rsp_valid, rsp_wen);
        end
        rst_n = 1'b1;
        idle();
        // R10 reset values and identity
        req(12'h340, 2'b10, 2'd3, 32'h0, 1'b0, 5'd0);
        req(12'hF11, 2'b11, 2'd3, 32'h0, 1'b1, 5'd0);
        // R2 swap, R3 set/clear, R4 immediate
        req(12'h340, 2'b01, 2'd3, 32'hA5A5_0F0F, 1'b0, 5'd0);
        req(12'h340, 2'b10, 2'd3, 32'h0000_F000, 1'b0, 5'd0);
        req(12'h340, 2'b11, 2'd3, 32'hA500_0000, 1'b0, 5'd0);
        req(12'h340, 2'b10, 2'd3, 32'hFFFF_FFFF, 1'b1, 5'd31);
        req(12'h340, 2'b01, 2'd3, 32'hDEAD_BEEF, 1'b1, 5'd9);
        req(12'h340, 2'b10, 2'd3, 32'h0, 1'b0, 5'd0);
        // R6 lower mode refused, state untouched
        req(12'h140, 2'b01, 2'd0, 32'h1234_5678, 1'b0, 5'd0);
        req(12'h240, 2'b01, 2'd1, 32'h1111_1111, 1'b0, 5'd0);
        req(12'h7A0, 2'b01, 2'd2, 32'h2222_2222, 1'b0, 5'd0);
        req(12'h140, 2'b10, 2'd1, 32'h0, 1'b0, 5'd0);
        req(12'h040, 2'b01, 2'd0, 32'h0000_00AA, 1'b0, 5'd0);
        // R7 read-only writes refused; R5 zero source on read-only is legal
        req(12'hC00, 2'b01, 2'd3, 32'h0, 1'b0, 5'd0);
        req(12'hF11, 2'b10, 2'd3, 32'h1, 1'b0, 5'd0);
        req(12'hC00, 2'b10, 2'd0, 32'h0, 1'b1, 5'd0);
        req(12'hF11, 2'b11, 2'd3, 32'h0, 1'b0, 5'd0);
        // R8 unimplemented and reserved op
        req(12'h041, 2'b10, 2'd3, 32'h0, 1'b0, 5'd0);
        req(12'h340, 2'b00, 2'd3, 32'h0, 1'b0, 5'd0);
        // R11 counter load and run
        req(12'hB00, 2'b01, 2'd3, 32'h0000_1000, 1'b0, 5'd0);
        idle(); idle();
        req(12'hC00, 2'b10, 2'd0, 32'h0, 1'b0, 5'd0);
        req(12'hB00, 2'b11, 2'd3, 32'h0000_00FF, 1'b0, 5'd0);
        req(12'hB00, 2'b10, 2'd1, 32'h0, 1'b0, 5'd0);
        idle();
        // mixed patterns
        for (int i = 0; i < 4000; i++) begin
            logic [11:0] a;
            int pick;
            pick = $urandom_range(0, 9);
            case (pick)
                0: a = 12'h040; 1: a = 12'h140; 2: a = 12'h240; 3: a = 12'h340;
                4: a = 12'h7A0; 5: a = 12'hB00; 6: a = 12'hC00; 7: a = 12'hF11;
                default: a = 12'($urandom);
            endcase
            if ($urandom_range(0, 7) == 0)
                idle();
            else
                req(a, 2'($urandom), 2'($urandom),
                    ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom,
                    1'($urandom), 5'($urandom));
        end
        idle(); idle();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule